// File: doc/BRIEF.md
# Interleaved SEC-DED Byte Memory

This block is a small synchronous byte-wide memory whose stored words protect themselves against soft upsets. On a write, the low nibble and the high nibble of the byte are each turned into an eight-bit extended Hamming codeword by two independent encoders. The two codewords are woven bit by bit into one sixteen-bit stored word: lane A takes the even positions and lane B the odd positions. A burst that flips two physically neighbouring cells therefore hits each codeword once, and both errors are corrected.

On a read, the stored word is split back into its two codewords. Each codeword is decoded, and a single error is corrected. A double error within one codeword is detected and flagged. The corrected byte and two per-lane flag pairs are registered, so they appear one cycle after the read. The array is never rewritten by a read. A bit-flip port XORs a sixteen-bit mask into any stored word, which models upsets.

Top module: `ilv_ecc_mem`

## Requirements
- R1: A write (`ce`=1, `we`=1) stores `wdata` at `addr`. A later read (`ce`=1, `we`=0) of that address returns the same byte on `rdata` in the cycle after the read. Both flag pairs are 0 when no bit was flipped.
- R2: Stored bit 2k+l carries bit k of the codeword of lane l. Lane 0 codes `wdata[3:0]` and lane 1 codes `wdata[7:4]`. Index 0 of `corr_flag` and `uncorr_flag` belongs to lane 0 and index 1 to lane 1. A flip at one position affects only the flags of its lane.
- R3: A single flipped bit at any of the 16 positions is corrected. `rdata` equals the written byte, the `corr_flag` bit of that lane is 1, and every other flag bit is 0.
- R4: Two flipped neighbouring bits 2k and 2k+1 are both corrected. `rdata` equals the written byte, `corr_flag`=2'b11 and `uncorr_flag`=2'b00.
- R5: Two flipped bits in the same lane set that lane's `uncorr_flag` bit and clear its `corr_flag` bit. The other lane's nibble and flags are unaffected.
- R6: `rdata`, `corr_flag` and `uncorr_flag` keep their values in every cycle without a read.
- R7: While `rst_n` is low, `rdata`, `corr_flag` and `uncorr_flag` are all 0.
- R8: A read does not repair the stored word. Reading a word with one flipped bit a second time again returns the corrected byte with the same `corr_flag`.
- R9: With `inj_en`=1, `inj_mask` is XORed into the word at `inj_addr` at the clock edge. A read in the same cycle returns the value from before the flip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Access enable |
| we | input | 1 | Write select when `ce` is high (1 = write, 0 = read) |
| addr | input | ADDR_W | Word address |
| wdata | input | 8 | Write byte |
| inj_en | input | 1 | Apply the bit-flip mask this cycle |
| inj_addr | input | ADDR_W | Address of the word to corrupt |
| inj_mask | input | 16 | Stored-word bits to invert |
| rdata | output | 8 | Corrected read byte, registered |
| corr_flag | output | 2 | Per-lane single error corrected |
| uncorr_flag | output | 2 | Per-lane double error detected |

## Verification
The hardest situation to reach from the ports is a stored word that carries a chosen error pattern: a single flip, a neighbouring pair that straddles the two lanes, or a pair confined to one lane. Normal writes always store clean codewords, so the bench reaches these patterns only through the bit-flip port. Each trial writes a fresh random byte, injects a mask of one of the three shapes at a random position, and reads the word twice. A directed sweep flips each of the 16 positions in turn, and the bench derives the expected flags from the count of flipped bits in each lane.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int NIB_W  = 4;
  localparam int LANES  = 2;
  localparam int CODE_W = 8;
  localparam int DATA_W = NIB_W * LANES;
  localparam int WORD_W = CODE_W * LANES;
endpackage

// File: rtl/ilv_secded_enc.sv
module ilv_secded_enc
  import ilv_pkg::*;
(
  input  logic [NIB_W-1:0]  nib,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-2:0] body;

  always_comb begin
    body[0] = nib[0] ^ nib[1] ^ nib[3];
    body[1] = nib[0] ^ nib[2] ^ nib[3];
    body[2] = nib[0];
    body[3] = nib[1] ^ nib[2] ^ nib[3];
    body[4] = nib[1];
    body[5] = nib[2];
    body[6] = nib[3];
    code    = {^body, body};
  end
endmodule

// File: rtl/ilv_secded_dec.sv
module ilv_secded_dec
  import ilv_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [NIB_W-1:0]  nib,
  output logic              fixed_one,
  output logic              bad_two
);
  logic [2:0]        syn;
  logic              par;
  logic [CODE_W-1:0] mend;

  always_comb begin
    syn[0] = code[0] ^ code[2] ^ code[4] ^ code[6];
    syn[1] = code[1] ^ code[2] ^ code[5] ^ code[6];
    syn[2] = code[3] ^ code[4] ^ code[5] ^ code[6];
    par    = ^code;
    mend   = code;
    if (par && (syn != 3'd0)) begin
      mend[syn - 3'd1] = ~code[syn - 3'd1];
    end
    nib       = {mend[6], mend[5], mend[4], mend[2]};
    fixed_one = par;
    bad_two   = !par && (syn != 3'd0);
  end
endmodule

// File: rtl/ilv_weave.sv
module ilv_weave
  import ilv_pkg::*;
(
  input  logic [CODE_W-1:0] lane_code [LANES],
  output logic [WORD_W-1:0] word
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
      assign word[i*LANES + l] = lane_code[l][i];
    end
  end
endmodule

// File: rtl/ilv_unweave.sv
module ilv_unweave
  import ilv_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [CODE_W-1:0] lane_code [LANES]
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
      assign lane_code[l][i] = word[i*LANES + l];
    end
  end
endmodule

// File: rtl/ilv_ecc_mem.sv
module ilv_ecc_mem
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                inj_en,
  input  logic [ADDR_W-1:0]   inj_addr,
  input  logic [WORD_W-1:0]   inj_mask,
  output logic [DATA_W-1:0]   rdata,
  output logic [LANES-1:0]    corr_flag,
  output logic [LANES-1:0]    uncorr_flag
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              wr_en;
  logic              rd_en;
  logic [CODE_W-1:0] wr_code [LANES];
  logic [CODE_W-1:0] rd_code [LANES];
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] cells [DEPTH];

  logic [DATA_W-1:0] dec_data;
  logic [LANES-1:0]  dec_corr;
  logic [LANES-1:0]  dec_unc;

  logic [DATA_W-1:0] rdata_q,  rdata_d;
  logic [LANES-1:0]  corr_q,   corr_d;
  logic [LANES-1:0]  unc_q,    unc_d;

  assign wr_en = ce && we;
  assign rd_en = ce && !we;

  for (genvar l = 0; l < LANES; l++) begin : g_enc
    ilv_secded_enc u_enc (
      .nib  (wdata[l*NIB_W +: NIB_W]),
      .code (wr_code[l])
    );
  end

  ilv_weave u_weave (
    .lane_code (wr_code),
    .word      (wr_word)
  );

  for (genvar e = 0; e < DEPTH; e++) begin : g_cell
    logic [WORD_W-1:0] cell_q;
    logic [WORD_W-1:0] cell_d;
    logic              hit_wr;
    logic              hit_inj;

    assign hit_wr  = wr_en  && (addr     == ADDR_W'(e));
    assign hit_inj = inj_en && (inj_addr == ADDR_W'(e));

    always_comb begin
      cell_d = hit_wr ? wr_word : cell_q;
      if (hit_inj) begin
        cell_d = cell_d ^ inj_mask;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_wr || hit_inj) begin
        cell_q <= cell_d;
      end
    end

    assign cells[e] = cell_q;
  end

  assign rd_word = cells[addr];

  ilv_unweave u_unweave (
    .word      (rd_word),
    .lane_code (rd_code)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_dec
    ilv_secded_dec u_dec (
      .code      (rd_code[l]),
      .nib       (dec_data[l*NIB_W +: NIB_W]),
      .fixed_one (dec_corr[l]),
      .bad_two   (dec_unc[l])
    );
  end

  always_comb begin
    rdata_d = rdata_q;
    corr_d  = corr_q;
    unc_d   = unc_q;
    if (rd_en) begin
      rdata_d = dec_data;
      corr_d  = dec_corr;
      unc_d   = dec_unc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      corr_q  <= '0;
      unc_q   <= '0;
    end else begin
      rdata_q <= rdata_d;
      corr_q  <= corr_d;
      unc_q   <= unc_d;
    end
  end

  assign rdata       = rdata_q;
  assign corr_flag   = corr_q;
  assign uncorr_flag = unc_q;
endmodule

// File: rtl/ilv_ecc_mem_chk.sv
module ilv_ecc_mem_chk
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              inj_en,
  input logic [DATA_W-1:0] rdata,
  input logic [LANES-1:0]  corr_flag,
  input logic [LANES-1:0]  uncorr_flag
);
  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_flag & uncorr_flag) == '0);

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce && !we) |=> $stable(rdata));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce && !we) |=> ($stable(corr_flag) && $stable(uncorr_flag)));

  // R1
  round_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ce && we && !inj_en) && ce && !we && !inj_en && (addr == $past(addr)))
    |=> ((rdata == $past(wdata, 2)) && (corr_flag == '0) && (uncorr_flag == '0)));
endmodule

bind ilv_ecc_mem ilv_ecc_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ce          (ce),
  .we          (we),
  .addr        (addr),
  .wdata       (wdata),
  .inj_en      (inj_en),
  .rdata       (rdata),
  .corr_flag   (corr_flag),
  .uncorr_flag (uncorr_flag)
);

// File: tb/tb_ilv_ecc_mem.sv
module tb_ilv_ecc_mem;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce, we, inj_en;
  logic [AW-1:0] addr, inj_addr;
  logic [7:0]    wdata;
  logic [15:0]   inj_mask;
  logic [7:0]    rdata;
  logic [1:0]    corr_flag, uncorr_flag;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [DEPTH];

  always #4 clk = ~clk;

  ilv_ecc_mem #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr), .wdata(wdata),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask),
    .rdata(rdata), .corr_flag(corr_flag), .uncorr_flag(uncorr_flag)
  );

  task automatic check(input logic ok, input string tag, input logic [11:0] act,
                       input logic [11:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ce = 0; we = 0; inj_en = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ce = 1; we = 1; addr = a; wdata = d; inj_en = 0;
    model[a] = d;
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [15:0] m);
    @(negedge clk);
    ce = 0; we = 0; inj_en = 1; inj_addr = a; inj_mask = m;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    ce = 1; we = 0; addr = a; inj_en = 0;
    @(negedge clk);
    ce = 0;
  endtask

  // Expected outcome from the count of flipped bits in each lane
  task automatic rd_check(input logic [AW-1:0] a, input logic [15:0] m, input string tag);
    logic [1:0] ec, eu;
    logic       ok;
    rd(a);
    ok = 1;
    for (int l = 0; l < 2; l++) begin
      int cnt = 0;
      for (int i = 0; i < 8; i++) cnt += int'(m[2*i + l]);
      ec[l] = (cnt == 1);
      eu[l] = (cnt == 2);
      if (cnt < 2 && rdata[4*l +: 4] != model[a][4*l +: 4]) ok = 0;
    end
    if (corr_flag != ec || uncorr_flag != eu) ok = 0;
    check(ok, tag, {corr_flag, uncorr_flag, rdata}, {ec, eu, model[a]});
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  hold_d;
    logic [15:0] m;
    int          seed;
    seed = $urandom(32'd4242);
    rst_n = 0; ce = 0; we = 0; inj_en = 0; addr = '0; inj_addr = '0;
    wdata = '0; inj_mask = '0;
    repeat (3) @(negedge clk);
    // R7
    check(rdata == 0 && corr_flag == 0 && uncorr_flag == 0, "R7 reset",
          {corr_flag, uncorr_flag, rdata}, 12'h0);
    rst_n = 1;

    // R1: fill and read back clean
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), 8'($urandom));
    for (int a = 0; a < DEPTH; a++) rd_check(AW'(a), 16'h0, "R1 clean");
    wr(4'd3, 8'hA5); rd_check(4'd3, 16'h0, "R1 back-to-back");

    // R2/R3: sweep each single position
    for (int p = 0; p < 16; p++) begin
      wr(4'd0, 8'($urandom));
      inject(4'd0, 16'(1) << p);
      rd_check(4'd0, 16'(1) << p, (p % 2 == 0) ? "R2 lane0 pos" : "R3 lane1 pos");
    end

    // R8: stored error not repaired by a read
    wr(4'd5, 8'h3C); inject(4'd5, 16'h0100);
    rd_check(4'd5, 16'h0100, "R3 first read");
    rd_check(4'd5, 16'h0100, "R8 second read");

    // R6: outputs hold without a read
    hold_d = rdata;
    idle(); wr(4'd6, ~hold_d); idle(); idle();
    check(rdata == hold_d && corr_flag == 2'b01, "R6 hold",
          {corr_flag, uncorr_flag, rdata}, {2'b01, 2'b00, hold_d});

    // R9: read in the same cycle as a flip sees the old word
    wr(4'd7, 8'h5A);
    @(negedge clk);
    ce = 1; we = 0; addr = 4'd7; inj_en = 1; inj_addr = 4'd7; inj_mask = 16'h0003;
    @(negedge clk);
    ce = 0; inj_en = 0;
    check(rdata == 8'h5A && corr_flag == 0 && uncorr_flag == 0, "R9 same-cycle",
          {corr_flag, uncorr_flag, rdata}, {4'b0, 8'h5A});
    rd_check(4'd7, 16'h0003, "R4 after same-cycle flip");

    // Random mix of error shapes
    for (int t = 0; t < 300; t++) begin
      logic [AW-1:0] a;
      int mode, k, l, i, j;
      a = AW'($urandom);
      wr(a, 8'($urandom));
      mode = int'($urandom % 4);
      k = int'($urandom % 8);
      l = int'($urandom % 2);
      i = int'($urandom % 8);
      j = (i + 1 + int'($urandom % 7)) % 8;
      case (mode)
        1: m = 16'(1) << (2*k + l);
        2: m = 16'(3) << (2*k);
        3: m = (16'(1) << (2*i + l)) | (16'(1) << (2*j + l));
        default: m = 16'h0;
      endcase
      if (m != 0) inject(a, m);
      case (mode)
        1: rd_check(a, m, "R3 random single");
        2: rd_check(a, m, "R4 random adjacent");
        3: rd_check(a, m, "R5 random same-lane");
        default: rd_check(a, m, "R1 random clean");
      endcase
      if (mode == 1) rd_check(a, m, "R8 random reread");
    end

    // Directed corners
    wr(4'd15, 8'hFF); inject(4'd15, 16'hC000); rd_check(4'd15, 16'hC000, "R4 top pair");
    wr(4'd14, 8'h00); inject(4'd14, 16'h0005); rd_check(4'd14, 16'h0005, "R5 lane0 pair");
    wr(4'd13, 8'h96); inject(4'd13, 16'h8002); rd_check(4'd13, 16'h8002, "R5 lane1 pair");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule